// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is a programmable down-counting timer for a processor's local interrupt controller. Software picks a clock divisor, programs a timer entry that holds an interrupt vector, a mask and a mode, and writes a start value into the initial-count register. The counter then steps down once per divided clock tick. When it reaches zero it raises an interrupt request that carries the programmed vector. The request stays up until software writes the end-of-interrupt register.

Two counting modes are supported. In one-shot mode the counter halts at zero after a single request. In periodic mode it reloads the initial value on the tick after zero and keeps going. The mask suppresses the request but leaves the counter running. Writing zero as the initial count halts the timer at once and no request follows. Software measures elapsed time by subtracting the current count from the value it loaded.

Registers are reached through a simple word-indexed port. A write is taken on the clock edge while the write strobe is high. Read data is combinational from the selected index.

Top module: `lic_timer`

## Requirements
- R1: After reset, the timer entry (index 0x32) reads 0x0001_0000: vector 0, mask set, one-shot mode, status 0. The divide register (0x3E), the initial count (0x38) and the current count (0x39) all read 0, and `irq_req` is low.
- R2: The divide register stores bits 3, 1 and 0 and reads the other bits as zero. Its codes give these divisors: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16, 8 gives 32, 9 gives 64, 10 gives 128 and 11 gives 1. Any write to it restarts the prescaler, so the first tick falls `divisor` cycles after the write edge.
- R3: A write of N to index 0x38 loads the counter with N. The counter then drops by one per prescaled tick, so N minus the current count equals the ticks seen. If the divide write happens one cycle before the count write, the request rises `N*d-1` cycles after the count-write edge, or `N` cycles when d is 1.
- R4: In one-shot mode (mode 0) the counter stays at 0 after its single expiry and raises no further request.
- R5: In periodic mode (mode 1) the counter reloads the initial value on the tick after it reaches zero. Successive requests are therefore `(N+1)*d` cycles apart.
- R6: Writing 0 to the initial count stops the timer. The current count then reads 0 and no request follows.
- R7: `irq_req` rises on the edge where the counter reaches zero, and `irq_vec` equals bits 7:0 of the timer entry. A write of any value to index 0x0B drops `irq_req` on that edge.
- R8: While the mask bit (bit 16) is set, no request is raised but the counter keeps running.
- R9: The delivery-status bit (bit 12 of the timer entry) reads 1 from expiry until end-of-interrupt. It reads 0 when idle or masked, and software cannot write it.
- R10: The mode field sits in bits 18:17 of the timer entry. Modes 2 and 3 count down like one-shot mode but never raise a request.
- R11: Reserved bits of the timer entry ignore writes and read as zero. Writes to the current-count index 0x39 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | IDX_W | Register word index |
| reg_we | input | 1 | Write strobe, taken on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx`, combinational |
| irq_req | output | 1 | Interrupt request, held until end-of-interrupt |
| irq_vec | output | 8 | Vector carried with the request |

## Verification
Register reads are combinational, so each read is sampled 1 ns after a falling edge, with no clock in between. A register write shows on the next falling edge. The request rises on the edge of the tick that brings the count to zero. Measured from the initial-count write, that edge comes `N*d-1` cycles later, or `N` cycles when d is 1, because the divide write always comes one cycle before it. The bench counts falling edges from the write up to the first high `irq_req` and compares that count with these formulas. For periodic runs it counts from one request to the next and expects `(N+1)*d`. End-of-interrupt is checked on the very next falling edge.

// File: rtl/lic_timer_pkg.sv
`timescale 1ns/1ps
package lic_timer_pkg;
   localparam int unsigned DATA_W = 32;

   // word indices of the register port
   localparam int unsigned IDX_EOI  = 'h0B;
   localparam int unsigned IDX_LVT  = 'h32;
   localparam int unsigned IDX_INIT = 'h38;
   localparam int unsigned IDX_CUR  = 'h39;
   localparam int unsigned IDX_DIV  = 'h3E;

   // timer entry bit positions
   localparam int unsigned LVT_STAT_BIT = 12;
   localparam int unsigned LVT_MASK_BIT = 16;
   localparam int unsigned LVT_MODE_LSB = 17;

   typedef enum logic [1:0] {
      MODE_ONCE     = 2'd0,
      MODE_PERIODIC = 2'd1,
      MODE_RSVD2    = 2'd2,
      MODE_RSVD3    = 2'd3
   } tmr_mode_e;

   // compact 3-bit form of the divide code: {bit3, bit1, bit0}
   function automatic logic [2:0] div_squeeze(input logic [3:0] raw);
      return {raw[3], raw[1:0]};
   endfunction
endpackage

// File: rtl/lic_timer_prescale.sv
`timescale 1ns/1ps
module lic_timer_prescale #(
   parameter int unsigned PRE_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [2:0] code,
   output logic       tick
);
   localparam int unsigned MIN_PRE_W = 7;

   if (PRE_W < MIN_PRE_W) begin : g_bad_pre
      $error("lic_timer_prescale: PRE_W must cover a divisor of 128");
   end

   logic [PRE_W-1:0] pre_q;
   logic [2:0]       shift;
   logic [PRE_W-1:0] limit;

   // code 7 selects divide-by-one, codes 0..6 select 2^(code+1)
   always_comb begin
      shift = (code == 3'd7) ? 3'd0 : code + 3'd1;
      limit = ~({PRE_W{1'b1}} << shift);
   end

   assign tick = (pre_q == limit) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (restart || pre_q == limit)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/lic_timer_count.sv
`timescale 1ns/1ps
module lic_timer_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             reload_en,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign expire = tick && running && (cnt == ONE) && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (load) begin
         cnt     <= load_val;
         running <= |load_val;
      end else if (tick && running) begin
         if (cnt == '0) begin
            // only reachable in periodic operation
            if (reload_en) cnt <= reload_val;
            else           running <= 1'b0;
         end else if (cnt == ONE) begin
            cnt <= '0;
            if (!reload_en) running <= 1'b0;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end
endmodule

// File: rtl/lic_timer_regs.sv
`timescale 1ns/1ps
module lic_timer_regs
   import lic_timer_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              expire,
   input  logic [DATA_W-1:0] cnt_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [7:0]        vec,
   output logic              mask,
   output tmr_mode_e         mode,
   output logic [2:0]        div_code,
   output logic              div_we,
   output logic              init_we,
   output logic [CNT_W-1:0]  init_val,
   output logic              irq_req
);
   logic lvt_we, eoi_we, pend_q, status, fire_ok;
   logic unused_wbits;

   assign unused_wbits = ^reg_wdata;

   assign lvt_we  = reg_we && (reg_idx == IDX_W'(IDX_LVT));
   assign init_we = reg_we && (reg_idx == IDX_W'(IDX_INIT));
   assign div_we  = reg_we && (reg_idx == IDX_W'(IDX_DIV));
   assign eoi_we  = reg_we && (reg_idx == IDX_W'(IDX_EOI));

   assign fire_ok = (mode == MODE_ONCE) || (mode == MODE_PERIODIC);
   assign status  = pend_q && !mask;
   assign irq_req = status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec      <= '0;
         mask     <= 1'b1;
         mode     <= MODE_ONCE;
         div_code <= 3'd0;
         init_val <= '0;
         pend_q   <= 1'b0;
      end else begin
         if (lvt_we) begin
            vec  <= reg_wdata[7:0];
            mask <= reg_wdata[LVT_MASK_BIT];
            mode <= tmr_mode_e'(reg_wdata[LVT_MODE_LSB +: 2]);
         end
         if (div_we)  div_code <= div_squeeze(reg_wdata[3:0]);
         if (init_we) init_val <= reg_wdata[CNT_W-1:0];
         // a new expiry wins over a same-cycle acknowledge
         if (expire && fire_ok && !mask) pend_q <= 1'b1;
         else if (eoi_we)                pend_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_idx)
         IDX_W'(IDX_LVT):  reg_rdata = {13'd0, mode, mask, 3'd0, status, 4'd0, vec};
         IDX_W'(IDX_INIT): reg_rdata = DATA_W'(init_val);
         IDX_W'(IDX_CUR):  reg_rdata = cnt_rd;
         IDX_W'(IDX_DIV):  reg_rdata = {28'd0, div_code[2], 1'b0, div_code[1:0]};
         default:          reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/lic_timer.sv
`timescale 1ns/1ps
module lic_timer
   import lic_timer_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PRE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_req,
   output logic [7:0]        irq_vec
);
   localparam int unsigned MIN_IDX_W = 6;

   if (IDX_W < MIN_IDX_W) begin : g_bad_idx
      $error("lic_timer: IDX_W too narrow for index 0x3E");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("lic_timer: CNT_W must lie in 2..32");
   end

   logic              tick, div_we, init_we, expire, cnt_run, lvt_mask;
   logic [2:0]        div_code;
   logic [7:0]        lvt_vec;
   tmr_mode_e         lvt_mode;
   logic [CNT_W-1:0]  init_val, cnt_val;
   logic [DATA_W-1:0] cnt_ext;

   if (CNT_W == DATA_W) begin : g_cnt_full
      assign cnt_ext = cnt_val;
   end else begin : g_cnt_narrow
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt_val};
   end

   lic_timer_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(div_we), .code(div_code), .tick(tick)
   );

   lic_timer_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(init_we), .load_val(reg_wdata[CNT_W-1:0]),
      .reload_val(init_val), .reload_en(lvt_mode == MODE_PERIODIC),
      .cnt(cnt_val), .running(cnt_run), .expire(expire)
   );

   lic_timer_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .expire(expire), .cnt_rd(cnt_ext),
      .reg_rdata(reg_rdata), .vec(lvt_vec), .mask(lvt_mask), .mode(lvt_mode),
      .div_code(div_code), .div_we(div_we), .init_we(init_we),
      .init_val(init_val), .irq_req(irq_req)
   );

   assign irq_vec = lvt_vec;
endmodule

// File: rtl/lic_timer_chk.sv
`timescale 1ns/1ps
module lic_timer_chk #(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] reg_idx,
   input logic             reg_we,
   input logic [31:0]      reg_wdata,
   input logic             irq_req,
   input logic             tick,
   input logic             expire,
   input logic             cnt_run,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] init_val,
   input logic             lvt_mask,
   input logic [1:0]       lvt_mode
);
   logic init_w, eoi_w;
   assign init_w = reg_we && (reg_idx == IDX_W'('h38));
   assign eoi_w  = reg_we && (reg_idx == IDX_W'('h0B));

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_run && cnt_val > CNT_W'(1) && !init_w) |=> (cnt_val == $past(cnt_val) - CNT_W'(1))); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_run && !init_w) |=> (!cnt_run && cnt_val == '0)); // R4
   AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_run && cnt_val == '0 && lvt_mode == 2'd1 && !init_w) |=> (cnt_val == $past(init_val))); // R5
   AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (init_w && reg_wdata[CNT_W-1:0] == '0) |=> (!cnt_run && cnt_val == '0)); // R6
   AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_w && !expire) |=> !irq_req); // R7
   AST_RISE_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ($past(expire) && !$past(lvt_mask))); // R8
   AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && lvt_mode[1] && !irq_req) |=> !irq_req); // R10
endmodule

bind lic_timer lic_timer_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
   .reg_wdata(reg_wdata), .irq_req(irq_req), .tick(tick), .expire(expire),
   .cnt_run(cnt_run), .cnt_val(cnt_val), .init_val(init_val),
   .lvt_mask(lvt_mask), .lvt_mode(lvt_mode)
);

// File: tb/sim_lic_timer.sv
`timescale 1ns/1ps
module sim_lic_timer;
   localparam logic [7:0] I_EOI = 8'h0B, I_LVT = 8'h32, I_INIT = 8'h38,
                          I_CUR = 8'h39, I_DIV = 8'h3E;

   logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, irq_req;
   logic [7:0]  reg_idx = '0, irq_vec;
   logic [31:0] reg_wdata = '0, reg_rdata;
   int unsigned n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   lic_timer u0 (.clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
                 .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
                 .irq_req(irq_req), .irq_vec(irq_vec));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic wr(input logic [7:0] idx, input logic [31:0] d);
      reg_idx = idx; reg_we = 1'b1; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] idx, output logic [31:0] d);
      reg_idx = idx; #1; d = reg_rdata; reg_idx = '0;
   endtask

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   function automatic int div_of(input logic [3:0] e);
      case (e)
         4'd0: return 2;   4'd1: return 4;   4'd2: return 8;    4'd3: return 16;
         4'd8: return 32;  4'd9: return 64;  4'd10: return 128; default: return 1;
      endcase
   endfunction

   function automatic logic [3:0] enc_of(input int k);
      return (k < 4) ? 4'(k) : 4'(k + 4);
   endfunction

   function automatic int lat(input int n, input int d);
      return (d == 1) ? n : n * d - 1;
   endfunction

   function automatic logic [31:0] lvt_word(input logic [7:0] v, input bit m, input logic [1:0] md);
      return {13'd0, md, m, 3'd0, 1'b0, 4'd0, v};
   endfunction

   // edges from the current falling edge until irq_req is seen, up to lim
   task automatic wait_irq(input int lim, output int n);
      n = 0;
      while (!irq_req && n < lim) begin step(1); n++; end
   endtask

   task automatic run_case(input logic [3:0] enc, input int n, input logic [1:0] md,
                           input bit m, input logic [7:0] v);
      int d, e, got, lim;
      logic [31:0] r;
      d = div_of(enc); e = lat(n, d); lim = e + 2 * d + 20;
      wr(I_LVT, lvt_word(v, m, md));
      wr(I_DIV, {28'd0, enc});
      wr(I_INIT, 32'(n));
      wait_irq(lim, got);
      if (m || md[1]) begin
         chk(!irq_req, m ? "R8" : "R10", "no request", 32'(irq_req), 0);
         rd(I_LVT, r);
         chk(r[12] == 1'b0, "R9", "status idle", r, r & ~32'h1000);
      end else begin
         chk(got == e, "R3", "expiry latency", got, e);
         chk(irq_vec == v, "R7", "vector", irq_vec, v);
         rd(I_LVT, r);
         chk(r[12] == 1'b1, "R9", "status pending", r, r | 32'h1000);
         if (md == 2'd1) begin
            wr(I_EOI, 32'h0);
            chk(!irq_req, "R7", "eoi clears", 32'(irq_req), 0);
            wait_irq((n + 1) * d + 10, got);
            chk(got + 1 == (n + 1) * d, "R5", "period", got + 1, (n + 1) * d);
         end else begin
            rd(I_CUR, r);
            chk(r == 0, "R4", "one-shot rests at zero", r, 0);
            wr(I_EOI, 32'h0);
            step((n + 2) * d);
            chk(!irq_req, "R4", "no second request", 32'(irq_req), 0);
         end
      end
      wr(I_INIT, 32'h0);
      wr(I_EOI, 32'h0);
   endtask

   initial begin
      #(5ns * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int n;
      void'($urandom(32'd1517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(I_LVT, r);  chk(r == 32'h0001_0000, "R1", "timer entry", r, 32'h0001_0000);
      rd(I_DIV, r);  chk(r == 0, "R1", "divide", r, 0);
      rd(I_INIT, r); chk(r == 0, "R1", "initial count", r, 0);
      rd(I_CUR, r);  chk(r == 0, "R1", "current count", r, 0);
      chk(!irq_req, "R1", "irq idle", 32'(irq_req), 0);

      // R11 reserved bits, status not writable; R2 divide storage
      wr(I_LVT, 32'hFFFF_FFFF);
      rd(I_LVT, r);  chk(r == 32'h0007_00FF, "R11", "reserved bits", r, 32'h0007_00FF);
      wr(I_DIV, 32'hFFFF_FFFF);
      rd(I_DIV, r);  chk(r == 32'hB, "R2", "divide storage", r, 32'hB);
      wr(I_CUR, 32'h1234);
      rd(I_CUR, r);  chk(r == 0, "R11", "current count read-only", r, 0);

      // R3 elapsed ticks with divide by 2
      wr(I_LVT, lvt_word(8'h30, 1'b0, 2'd0));
      wr(I_DIV, 32'h0);
      wr(I_INIT, 32'd100);
      step(20);
      rd(I_CUR, r);  chk(r == 90, "R3", "count after 20 cycles", r, 90);
      rd(I_INIT, r); chk(r == 100, "R3", "initial readback", r, 100);

      // R6 zero stops the timer
      wr(I_INIT, 32'h0);
      rd(I_CUR, r);  chk(r == 0, "R6", "stopped count", r, 0);
      wait_irq(300, n);
      chk(!irq_req, "R6", "no request after stop", 32'(irq_req), 0);

      // R8 masked: counter still runs
      wr(I_LVT, lvt_word(8'h41, 1'b1, 2'd0));
      wr(I_DIV, 32'hB);
      wr(I_INIT, 32'd50);
      step(10);
      rd(I_CUR, r);  chk(r == 40, "R8", "masked counter runs", r, 40);
      wr(I_INIT, 32'h0);

      // R2 every divide code, one-shot
      for (int k = 0; k < 8; k++) run_case(enc_of(k), 2, 2'd0, 1'b0, 8'(8'h50 + k));
      // R10 reserved modes
      run_case(4'hB, 3, 2'd2, 1'b0, 8'h22);
      run_case(4'h1, 2, 2'd3, 1'b0, 8'h23);
      // R5 periodic directed
      run_case(4'hB, 1, 2'd1, 1'b0, 8'h60);
      run_case(4'h2, 4, 2'd1, 1'b0, 8'h61);

      // constrained random
      for (int i = 0; i < 14; i++) begin
         logic [3:0] enc = enc_of(int'($urandom % 8));
         int cnt = 1 + int'($urandom % 6);
         logic [1:0] md = 2'($urandom % 2);
         bit m = (($urandom % 4) == 0);
         run_case(enc, cnt, md, m, 8'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule